// File: doc/BRIEF.md
# Event-Triggered Delay Channel

This block is one output channel of a timing receiver. Every decoded 32-bit event frame is compared against a programmed pattern under a per-bit compare mask. A hit loads a 22-bit delay into a down-counter. Counting begins on a chosen start condition and advances on a chosen tick source. When the count expires, the channel emits an output pulse of programmable width and can raise a one-cycle interrupt. A telegram-condition strobe can replace the frame compare as the trigger.

Three modes set what happens after expiry. Once mode returns to idle. Multi mode reloads the delay and keeps pulsing until a stop code arrives. Burst mode also reloads, but pulses only while an external gate input is high. Two further event codes open and close an enable gate. While the gate is closed, ticks neither advance the counter nor produce output.

Frames use this layout: bits [31:28] hold the machine, bits [27:24] the type, bits [23:16] the code and bits [15:0] the payload. The gate-open, gate-close and stop commands are recognised on the code field alone.

The controller has three states: `ST_IDLE`, `ST_WAIT` (armed, waiting for the start condition) and `ST_COUNT`. The transitions are:
- arm: a trigger hit from any state goes to `ST_COUNT` when the start source is the trigger, and to `ST_WAIT` otherwise.
- start: `ST_WAIT` goes to `ST_COUNT` on the start condition.
- expire: `ST_COUNT` goes to `ST_IDLE` at terminal count in once mode.
- cancel: a stop code from any active state goes to `ST_IDLE`.

Top module: `evt_delay_channel`

## Requirements
- R1: After reset `out_pulse` and `irq` are low, the channel is idle and the enable gate is open.
- R2: A valid frame triggers when it equals `cfg_pattern` on every bit where `cfg_mask` is 1. Bits where the mask is 0 are ignored, so an all-ones mask demands an exact match.
- R3: With `cfg_use_tgm`=1 only the `tgm_hit` strobe triggers, and frames are ignored for triggering.
- R4: With the internal tick and start-on-trigger, a trigger sampled at clock edge E raises `out_pulse` at edge E+1+D, where D is `cfg_delay`. D=0 behaves as D=1.
- R5: `out_pulse` stays high for `cfg_width` clock cycles (0 behaves as 1), counted on the system clock whatever the tick source.
- R6: A new trigger during a wait or a countdown reloads the delay and restarts the count, and the earlier pending pulse is dropped.
- R7: `cfg_start_sel` picks the start condition: 0 is the trigger itself, 1 is a `prev_done` pulse (the count starts at the next edge), 2 is a rising edge of `ext_start` after a two-flop synchroniser. `prev_done` while idle does nothing.
- R8: `cfg_clk_sel` picks the tick: 0 is every clock, 1 is one clock in `HARM_DIV`, 2 is a synchronised edge of `ext_clk`, rising when `cfg_ext_fall`=0 and falling when it is 1.
- R9: `cfg_mode`=0 (once) gives exactly one pulse per trigger, then returns to idle.
- R10: `cfg_mode`=1 (multi) pulses every D ticks until a frame with code `cfg_stop_code` arrives.
- R11: `cfg_mode`=2 (burst) reloads like multi mode, but a pulse is emitted only while synchronised `ext_gate` is high. `cfg_stop_code` ends the burst.
- R12: Code `cfg_dis_code` closes the enable gate and `cfg_en_code` opens it. With the gate closed, ticks leave the count unchanged and produce no pulse. A delay-1 channel clocked by a falling flag therefore pulses only on a fall that arrives after the gate is reopened.
- R13: With `cfg_irq_en`=1 every emitted pulse gives a one-cycle `irq` at the cycle the pulse starts. With `cfg_irq_en`=0 `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (40 MHz-derived) |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Frame strobe |
| evt_frame | input | 32 | Decoded event frame |
| tgm_hit | input | 1 | Telegram condition strobe |
| prev_done | input | 1 | Expiry pulse of the neighbouring channel |
| ext_start | input | 1 | Asynchronous external start |
| ext_clk | input | 1 | Asynchronous external tick source |
| ext_gate | input | 1 | Asynchronous burst gate |
| cfg_pattern | input | 32 | Trigger pattern |
| cfg_mask | input | 32 | Compare mask, 1 means compare |
| cfg_use_tgm | input | 1 | Trigger from telegram strobe |
| cfg_en_code | input | 8 | Gate-open code |
| cfg_dis_code | input | 8 | Gate-close code |
| cfg_stop_code | input | 8 | Stop code |
| cfg_delay | input | 22 | Delay in ticks |
| cfg_width | input | 16 | Pulse width in clocks |
| cfg_mode | input | 2 | 0 once, 1 multi, 2 burst |
| cfg_start_sel | input | 2 | 0 trigger, 1 previous channel, 2 external |
| cfg_clk_sel | input | 2 | 0 internal, 1 harmonic, 2 external |
| cfg_ext_fall | input | 1 | Use falling edge of `ext_clk` |
| cfg_irq_en | input | 1 | Interrupt enable |
| out_pulse | output | 1 | Channel output |
| irq | output | 1 | Interrupt pulse |

## Verification
A fault in the down-counter or the controller shows up on `out_pulse` in the very expiry window it upsets. The pulse comes a cycle early or late, goes missing, or appears with no expectation pending. The scoreboard holds a start window and a width for every expected pulse, so any such slip is caught at the first pulse it affects. A stuck enable gate, stop decoding or burst gate shows as surplus or missing pulses within one reload period. An interrupt fault shows as a mismatch in the interrupt tally at the end of each case.

// File: rtl/evdc_pkg.sv
package evdc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_COUNT = 2'd2
    } chan_state_e;

    typedef enum logic [1:0] {
        MODE_ONCE  = 2'd0,
        MODE_MULTI = 2'd1,
        MODE_BURST = 2'd2
    } chan_mode_e;

    typedef enum logic [1:0] {
        START_TRIG = 2'd0,
        START_PREV = 2'd1,
        START_EXT  = 2'd2
    } start_src_e;

    typedef enum logic [1:0] {
        TICK_INT  = 2'd0,
        TICK_HARM = 2'd1,
        TICK_EXT  = 2'd2
    } tick_src_e;
endpackage

// File: rtl/evdc_sync.sv
module evdc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/evdc_matcher.sv
module evdc_matcher #(
    parameter int FRAME_W  = 32,
    parameter int CODE_W   = 8,
    parameter int CODE_LSB = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid,
    input  logic [FRAME_W-1:0] evt_frame,
    input  logic               tgm_hit,
    input  logic [FRAME_W-1:0] cfg_pattern,
    input  logic [FRAME_W-1:0] cfg_mask,
    input  logic               cfg_use_tgm,
    input  logic [CODE_W-1:0]  cfg_en_code,
    input  logic [CODE_W-1:0]  cfg_dis_code,
    input  logic [CODE_W-1:0]  cfg_stop_code,
    output logic               hit_q,
    output logic               stop_q,
    output logic               gate_en_q
);
    logic [CODE_W-1:0] code;
    logic              frame_hit;

    assign code      = evt_frame[CODE_LSB +: CODE_W];
    assign frame_hit = evt_valid && (((evt_frame ^ cfg_pattern) & cfg_mask) == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q     <= 1'b0;
            stop_q    <= 1'b0;
            gate_en_q <= 1'b1;
        end else begin
            hit_q  <= cfg_use_tgm ? tgm_hit : frame_hit;
            stop_q <= evt_valid && (code == cfg_stop_code);
            if (evt_valid && code == cfg_en_code)
                gate_en_q <= 1'b1;
            else if (evt_valid && code == cfg_dis_code)
                gate_en_q <= 1'b0;
        end
    end

    // R2
    hit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> $past(evt_valid || tgm_hit));
endmodule

// File: rtl/evdc_tickgen.sv
module evdc_tickgen #(
    parameter int HARM_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_clk_sel,
    input  logic       cfg_ext_fall,
    input  logic       ext_clk,
    output logic       tick
);
    import evdc_pkg::*;

    localparam int DIV_W = (HARM_DIV > 2) ? $clog2(HARM_DIV) : 1;

    logic [DIV_W-1:0] div_q;
    logic             xc_s, xc_prev;

    evdc_sync #(.STAGES(2)) u_xclk_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_clk), .q(xc_s)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= '0;
            xc_prev <= 1'b0;
        end else begin
            div_q   <= (div_q == DIV_W'(HARM_DIV - 1)) ? '0 : div_q + 1'b1;
            xc_prev <= xc_s;
        end
    end

    always_comb begin
        unique case (tick_src_e'(cfg_clk_sel))
            TICK_INT:  tick = 1'b1;
            TICK_HARM: tick = (div_q == DIV_W'(HARM_DIV - 1));
            TICK_EXT:  tick = cfg_ext_fall ? (!xc_s && xc_prev) : (xc_s && !xc_prev);
            default:   tick = 1'b0;
        endcase
    end

    // R8
    harm_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_src_e'(cfg_clk_sel) == TICK_HARM && tick)
            |=> (!tick || tick_src_e'(cfg_clk_sel) != TICK_HARM));
endmodule

// File: rtl/evdc_pulse.sv
module evdc_pulse #(
    parameter int PW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic [PW_W-1:0] cfg_width,
    output logic            out_pulse
);
    logic [PW_W-1:0] left_q;
    logic [PW_W-1:0] width_eff;

    assign width_eff = (cfg_width == '0) ? PW_W'(1) : cfg_width;

    always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (fire)           left_q <= width_eff;
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign out_pulse = (left_q != '0);

    // R5
    fire_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_pulse);
endmodule

// File: rtl/evt_delay_channel.sv
module evt_delay_channel #(
    parameter int FRAME_W  = 32,
    parameter int CODE_W   = 8,
    parameter int CODE_LSB = 16,
    parameter int DLY_W    = 22,
    parameter int PW_W     = 16,
    parameter int HARM_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid,
    input  logic [FRAME_W-1:0] evt_frame,
    input  logic               tgm_hit,
    input  logic               prev_done,
    input  logic               ext_start,
    input  logic               ext_clk,
    input  logic               ext_gate,
    input  logic [FRAME_W-1:0] cfg_pattern,
    input  logic [FRAME_W-1:0] cfg_mask,
    input  logic               cfg_use_tgm,
    input  logic [CODE_W-1:0]  cfg_en_code,
    input  logic [CODE_W-1:0]  cfg_dis_code,
    input  logic [CODE_W-1:0]  cfg_stop_code,
    input  logic [DLY_W-1:0]   cfg_delay,
    input  logic [PW_W-1:0]    cfg_width,
    input  logic [1:0]         cfg_mode,
    input  logic [1:0]         cfg_start_sel,
    input  logic [1:0]         cfg_clk_sel,
    input  logic               cfg_ext_fall,
    input  logic               cfg_irq_en,
    output logic               out_pulse,
    output logic               irq
);
    import evdc_pkg::*;

    chan_state_e      state_q, state_d;
    logic [DLY_W-1:0] cnt_q, cnt_d, delay_eff;
    logic             hit, stop, gate_en, tick;
    logic             xs_s, xs_prev, xs_rise, gate_s;
    logic             start_ev, at_term, emit, irq_q;
    chan_mode_e       mode;

    assign mode      = chan_mode_e'(cfg_mode);
    assign delay_eff = (cfg_delay == '0) ? DLY_W'(1) : cfg_delay;

    evdc_matcher #(.FRAME_W(FRAME_W), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB)) u_match (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_frame(evt_frame),
        .tgm_hit(tgm_hit), .cfg_pattern(cfg_pattern), .cfg_mask(cfg_mask),
        .cfg_use_tgm(cfg_use_tgm), .cfg_en_code(cfg_en_code),
        .cfg_dis_code(cfg_dis_code), .cfg_stop_code(cfg_stop_code),
        .hit_q(hit), .stop_q(stop), .gate_en_q(gate_en)
    );

    evdc_tickgen #(.HARM_DIV(HARM_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .cfg_clk_sel(cfg_clk_sel),
        .cfg_ext_fall(cfg_ext_fall), .ext_clk(ext_clk), .tick(tick)
    );

    evdc_sync #(.STAGES(2)) u_xstart_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_start), .q(xs_s)
    );

    evdc_sync #(.STAGES(2)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_gate), .q(gate_s)
    );

    evdc_pulse #(.PW_W(PW_W)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(emit), .cfg_width(cfg_width),
        .out_pulse(out_pulse)
    );

    assign xs_rise = xs_s && !xs_prev;

    always_comb begin
        unique case (start_src_e'(cfg_start_sel))
            START_PREV: start_ev = prev_done;
            START_EXT:  start_ev = xs_rise;
            default:    start_ev = 1'b1;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            xs_prev <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            xs_prev <= xs_s;
            irq_q   <= emit && cfg_irq_en;
        end
    end

    // Output process
    always_comb begin
        at_term = (state_q == ST_COUNT) && tick && gate_en &&
                  (cnt_q == DLY_W'(1)) && !hit && !stop;
        emit    = at_term && ((mode != MODE_BURST) || gate_s);
    end

    // Next-state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (hit) begin
            state_d = (start_src_e'(cfg_start_sel) == START_TRIG) ? ST_COUNT : ST_WAIT;
            cnt_d   = delay_eff;
        end else if (stop && state_q != ST_IDLE) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_WAIT: begin
                    if (start_ev) begin
                        state_d = ST_COUNT;
                        cnt_d   = delay_eff;
                    end
                end
                ST_COUNT: begin
                    if (tick && gate_en) begin
                        cnt_d = (cnt_q == DLY_W'(1)) ? delay_eff : cnt_q - 1'b1;
                        if (at_term && mode != MODE_MULTI && mode != MODE_BURST)
                            state_d = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign irq = irq_q;

    // R9
    once_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_term && mode == MODE_ONCE) |=> state_q == ST_IDLE);

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt_q == $past(delay_eff)) && state_q != ST_IDLE);

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && tick && gate_en && cnt_q > DLY_W'(1) && !hit && !stop)
            |=> cnt_q == $past(cnt_q) - DLY_W'(1));

    // R12
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !gate_en && !hit && !stop) |=> $stable(cnt_q));

    // R11
    burst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BURST && !gate_s) |=> !irq);

    // R13
    irq_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> out_pulse);
endmodule

// File: tb/evt_delay_channel_tb.sv
module evt_delay_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [31:0] evt_frame = '0;
    logic        tgm_hit = 1'b0, prev_done = 1'b0, ext_start = 1'b0;
    logic        ext_clk = 1'b1, ext_gate = 1'b0;
    logic [31:0] cfg_pattern, cfg_mask;
    logic        cfg_use_tgm;
    logic [7:0]  cfg_en_code, cfg_dis_code, cfg_stop_code;
    logic [21:0] cfg_delay;
    logic [15:0] cfg_width;
    logic [1:0]  cfg_mode, cfg_start_sel, cfg_clk_sel;
    logic        cfg_ext_fall, cfg_irq_en;
    logic        out_pulse, irq;

    evt_delay_channel u_dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_frame(evt_frame),
        .tgm_hit(tgm_hit), .prev_done(prev_done), .ext_start(ext_start),
        .ext_clk(ext_clk), .ext_gate(ext_gate), .cfg_pattern(cfg_pattern),
        .cfg_mask(cfg_mask), .cfg_use_tgm(cfg_use_tgm), .cfg_en_code(cfg_en_code),
        .cfg_dis_code(cfg_dis_code), .cfg_stop_code(cfg_stop_code),
        .cfg_delay(cfg_delay), .cfg_width(cfg_width), .cfg_mode(cfg_mode),
        .cfg_start_sel(cfg_start_sel), .cfg_clk_sel(cfg_clk_sel),
        .cfg_ext_fall(cfg_ext_fall), .cfg_irq_en(cfg_irq_en),
        .out_pulse(out_pulse), .irq(irq)
    );

    always #4 clk = ~clk;

    localparam logic [31:0] PAT = 32'h1402_0005;

    typedef struct {
        longint lo;
        longint hi;
        int     w;
        string  req;
    } exp_t;

    exp_t   exp_q[$];
    longint cyc = 0;
    int     n_chk = 0, n_bad = 0;
    int     rises = 0, irq_seen = 0, hi_len = 0, cur_w = 0;
    string  cur_req = "R1";
    bit     mon_prev = 1'b0;
    bit     done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: pops expectations as pulses start
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_pulse && !mon_prev) begin
                rises++;
                hi_len = 1;
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_req, "unexpected pulse at cycle", cyc, -1);
                    cur_w = 0;
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cyc >= e.lo && cyc <= e.hi, e.req, "pulse start cycle", cyc, e.lo);
                    cur_w = e.w;
                    cur_req = e.req;
                end
            end else if (out_pulse) begin
                hi_len++;
            end else if (mon_prev && cur_w != 0) begin
                check(hi_len == cur_w, cur_req, "pulse width", hi_len, cur_w);
            end
            if (irq) irq_seen++;
            mon_prev = out_pulse;
        end
    end

    task automatic expect_pulse(input longint lo, input longint hi, input int w, input string req);
        exp_t e;
        e.lo = lo; e.hi = hi; e.w = w; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic send_frame(input logic [31:0] f, output longint k);
        evt_valid = 1'b1;
        evt_frame = f;
        k = cyc;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic wait_until(input longint c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic defaults();
        cfg_pattern = PAT; cfg_mask = 32'hFFFF_FFFF; cfg_use_tgm = 1'b0;
        cfg_en_code = 8'hE1; cfg_dis_code = 8'hD1; cfg_stop_code = 8'h5F;
        cfg_delay = 22'd5; cfg_width = 16'd3; cfg_mode = 2'd0;
        cfg_start_sel = 2'd0; cfg_clk_sel = 2'd0; cfg_ext_fall = 1'b0; cfg_irq_en = 1'b1;
    endtask

    task automatic close_case(input string req, input int irq_before, input int irq_exp);
        idle(30);
        check(exp_q.size() == 0, req, "missing pulses", exp_q.size(), 0);
        exp_q.delete();
        check(irq_seen - irq_before == irq_exp, req, "irq count", irq_seen - irq_before, irq_exp);
    endtask

    initial begin
        if (!done) begin
            wait (cyc >= 100000);
            if (!done) begin
                check(1'b0, "R1", "watchdog expired", cyc, 100000);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        longint k, k2, m, s;
        int     ib, rb;
        defaults();
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(out_pulse == 1'b0, "R1", "out_pulse after reset", out_pulse, 0);
        check(irq == 1'b0, "R1", "irq after reset", irq, 0);

        // R4 R5 R9 R13: once mode, internal tick
        cur_req = "R4"; ib = irq_seen;
        send_frame(PAT, k);
        expect_pulse(k + 7, k + 7, 3, "R4");
        close_case("R9", ib, 1);

        // R4 delay zero behaves as one
        cfg_delay = 22'd0; cfg_width = 16'd1; ib = irq_seen;
        send_frame(PAT, k);
        expect_pulse(k + 3, k + 3, 1, "R4");
        close_case("R4", ib, 1);
        defaults();

        // R2 exact mismatch must not trigger
        cur_req = "R2"; rb = rises; ib = irq_seen;
        send_frame(32'h1402_0006, k);
        close_case("R2", ib, 0);
        check(rises == rb, "R2", "pulses on mismatch", rises - rb, 0);

        // R2 wildcard on payload
        cfg_mask = 32'hFFFF_0000; ib = irq_seen;
        send_frame(32'h1402_ABCD, k);
        expect_pulse(k + 7, k + 7, 3, "R2");
        close_case("R2", ib, 1);
        rb = rises;
        send_frame(32'h1403_0005, k);
        close_case("R2", irq_seen, 0);
        check(rises == rb, "R2", "pulses on masked mismatch", rises - rb, 0);
        defaults();

        // R3 telegram trigger
        cur_req = "R3"; cfg_use_tgm = 1'b1; rb = rises;
        send_frame(PAT, k);
        idle(15);
        check(rises == rb, "R3", "frame trigger in telegram mode", rises - rb, 0);
        tgm_hit = 1'b1; k = cyc; @(negedge clk); tgm_hit = 1'b0;
        expect_pulse(k + 7, k + 7, 3, "R3");
        close_case("R3", irq_seen, 1);
        defaults();

        // R6 retrigger restarts the count
        cur_req = "R6"; cfg_delay = 22'd10; ib = irq_seen;
        send_frame(PAT, k);
        idle(4);
        send_frame(PAT, k2);
        expect_pulse(k2 + 12, k2 + 12, 3, "R6");
        close_case("R6", ib, 1);
        defaults();

        // R7 start from previous channel
        cur_req = "R7"; cfg_start_sel = 2'd1; cfg_delay = 22'd4; rb = rises;
        prev_done = 1'b1; @(negedge clk); prev_done = 1'b0;
        idle(10);
        check(rises == rb, "R7", "prev_done while idle", rises - rb, 0);
        send_frame(PAT, k);
        idle(5);
        prev_done = 1'b1; m = cyc; @(negedge clk); prev_done = 1'b0;
        expect_pulse(m + 5, m + 5, 3, "R7");
        close_case("R7", irq_seen, 1);

        // R7 external start
        cfg_start_sel = 2'd2;
        send_frame(PAT, k);
        idle(6);
        expect_pulse(cyc + 6, cyc + 8, 3, "R7");
        ext_start = 1'b1;
        idle(4);
        ext_start = 1'b0;
        close_case("R7", irq_seen, 1);
        defaults();

        // R8 harmonic tick, delay 3, divide 4
        cur_req = "R8"; cfg_clk_sel = 2'd1; cfg_delay = 22'd3;
        send_frame(PAT, k);
        expect_pulse(k + 10, k + 13, 3, "R8");
        close_case("R8", irq_seen, 1);
        defaults();

        // R12 R8 falling flag as tick, delay 1, gated
        cur_req = "R12"; cfg_clk_sel = 2'd2; cfg_ext_fall = 1'b1;
        cfg_delay = 22'd1; cfg_width = 16'd2;
        idle(5);
        send_frame(32'h1100_0000 | (32'(8'hD1) << 16), k);
        send_frame(PAT, k);
        idle(3);
        ext_clk = 1'b0;
        idle(10);
        ext_clk = 1'b1;
        idle(8);
        send_frame(32'h1100_0000 | (32'(8'hE1) << 16), k);
        idle(2);
        expect_pulse(cyc + 2, cyc + 5, 2, "R12");
        ext_clk = 1'b0;
        close_case("R12", irq_seen, 1);
        ext_clk = 1'b1;
        idle(5);
        defaults();

        // R10 multi mode until stop
        cur_req = "R10"; cfg_mode = 2'd1; cfg_width = 16'd2; ib = irq_seen;
        send_frame(PAT, k);
        expect_pulse(k + 7, k + 7, 2, "R10");
        expect_pulse(k + 12, k + 12, 2, "R10");
        expect_pulse(k + 17, k + 17, 2, "R10");
        wait_until(k + 18);
        send_frame(32'h1100_0000 | (32'(8'h5F) << 16), s);
        close_case("R10", ib, 3);
        defaults();

        // R11 burst gated by ext_gate
        cur_req = "R11"; cfg_mode = 2'd2; cfg_delay = 22'd4; cfg_width = 16'd1; ib = irq_seen;
        send_frame(PAT, k);
        expect_pulse(k + 14, k + 14, 1, "R11");
        expect_pulse(k + 18, k + 18, 1, "R11");
        wait_until(k + 11);
        ext_gate = 1'b1;
        wait_until(k + 19);
        ext_gate = 1'b0;
        wait_until(k + 24);
        send_frame(32'h1100_0000 | (32'(8'h5F) << 16), s);
        close_case("R11", ib, 2);
        defaults();

        // R13 interrupt disabled
        cur_req = "R13"; cfg_irq_en = 1'b0; ib = irq_seen;
        send_frame(PAT, k);
        expect_pulse(k + 7, k + 7, 3, "R13");
        close_case("R13", ib, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule